// File: doc/BRIEF.md
# D-PHY Receiver Test-Code Register Port

This block is the target side of the slow configuration port of a D-PHY receiver. It keeps a small set of 8-bit settings registers that the analog receive lanes consume: one HS receive control byte for the clock lane, one for each of four data lanes, and a settle-time counter threshold for the data lanes. Each register is selected by an 8-bit test code.

Address and data share one 8-bit input bus. A phase input tells them apart, and so does the edge of the port strobe on which the bus is taken. With the phase input high, a falling strobe edge captures the bus as the current code. With the phase input low, a rising strobe edge stores the bus into the register at the current code. The strobe, phase and clear inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found from the synchronized values. The read-back output always shows the register at the current code. A flag reports normal operation: it drops when a code is captured and comes back when data 0x00 is written at code 0x00.

Top module: `tc_port`

## Requirements
- R1: After reset, tc_q_o, clk_lane_cfg_o, data_lane_cfg_o and settle_cfg_o are all 0x00 and normal_o is 1.
- R2: A falling edge on tc_clk_i while tc_addr_i is high makes tc_d_i the current code. tc_q_o then shows the register at that code.
- R3: A rising edge on tc_clk_i while tc_addr_i is low stores tc_d_i into the register at the current code. The new value reaches the configuration outputs and tc_q_o within 4 clk_i cycles of the edge.
- R4: A rising edge on tc_clk_i while tc_addr_i is high writes no register.
- R5: A falling edge on tc_clk_i while tc_addr_i is low leaves the current code unchanged.
- R6: While the current code is not one of 0x34, 0x44, 0x54, 0x84, 0x94 or 0x75, tc_q_o reads 0x00, and a write changes no implemented register.
- R7: Code 0x34 drives clk_lane_cfg_o. Codes 0x44, 0x54, 0x84 and 0x94 drive data_lane_cfg_o bits [7:0], [15:8], [23:16] and [31:24] (lanes 0 to 3). Code 0x75 drives settle_cfg_o.
- R8: normal_o falls when a code is captured (R2). It rises again only on a write of data 0x00 at code 0x00, or on a clear (R9).
- R9: While tc_clr_i is high, all registers and the current code are cleared to 0x00 and normal_o is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tc_clk_i | input | 1 | Port strobe, asynchronous |
| tc_addr_i | input | 1 | Phase select: 1 = code phase, 0 = data phase |
| tc_clr_i | input | 1 | Level clear of code and registers |
| tc_d_i | input | 8 | Shared code/data bus |
| tc_q_o | output | 8 | Register at current code, 0x00 if unimplemented |
| normal_o | output | 1 | High in normal operation |
| clk_lane_cfg_o | output | 8 | Clock lane HS receive control |
| data_lane_cfg_o | output | 32 | Data lane HS receive controls, lane n at [8n+7:8n] |
| settle_cfg_o | output | 8 | Data lane settle counter threshold |

## Verification
The bench drives strobe edges in the wrong phase: a rising edge with the phase high, followed by a falling edge with it low. A design that decoded the edges loosely would either store the code byte as data or overwrite the code with the data byte. Writes to unimplemented codes, among them 0x00, must leave the six registers unchanged. A loose address decoder would alias them onto a lane register. The normal flag is checked around writes at code 0x00 with zero and with non-zero data, and around clears in the middle of a sequence, where a stale code would leave read-back showing an old register.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int DW   = 8;
  localparam int NREG = 6;
  // index 0: clock lane, 1..4: data lanes 0..3, 5: settle threshold
  localparam logic [NREG*DW-1:0] REG_CODES = {8'h75, 8'h94, 8'h84, 8'h54, 8'h44, 8'h34};
  localparam logic [DW-1:0] NORMAL_CODE = 8'h00;
  localparam logic [DW-1:0] NORMAL_DATA = 8'h00;
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tc_ctl.sv
module tc_ctl
  import tc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strb_s_i,
  input  logic          addr_s_i,
  input  logic          clr_s_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] code_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          normal_o
);
  logic          strb_prev_q;
  logic          rise, fall, cap;
  logic [DW-1:0] code_q;
  logic          normal_q;

  assign rise = strb_s_i & ~strb_prev_q;
  assign fall = ~strb_s_i & strb_prev_q;
  assign cap  = fall & addr_s_i & ~clr_s_i;
  assign we_o = rise & ~addr_s_i & ~clr_s_i;
  assign wdata_o = bus_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev_q <= 1'b0;
      code_q      <= '0;
      normal_q    <= 1'b1;
    end else begin
      strb_prev_q <= strb_s_i;
      if (clr_s_i) begin
        code_q   <= '0;
        normal_q <= 1'b1;
      end else if (cap) begin
        code_q   <= bus_i;
        normal_q <= 1'b0;
      end else if (we_o && code_q == NORMAL_CODE && bus_i == NORMAL_DATA) begin
        normal_q <= 1'b1;
      end
    end
  end

  assign code_o   = code_q;
  assign normal_o = normal_q;

  assert_code_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fall && addr_s_i) && !clr_s_i) |=> $stable(code_q));

  assert_normal_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(normal_q) |-> ($past(clr_s_i) ||
      $past(we_o && code_q == NORMAL_CODE && wdata_o == NORMAL_DATA)));
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile
  import tc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [DW-1:0]      code_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] q_all_o,
  output logic [NREG-1:0]    hit_o,
  output logic [DW-1:0]      rdata_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    assign hit_o[g] = (code_i == REG_CODES[g*DW +: DW]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= '0;
      else if (clr_i)             q <= '0;
      else if (we_i && hit_o[g])  q <= wdata_i;
    end

    assign q_all_o[g*DW +: DW] = q;

    assert_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && hit_o[g] && !clr_i) |=> (q == $past(wdata_i)));

    assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (q == '0));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (hit_o[i]) rdata_o = rdata_o | q_all_o[i*DW +: DW];
  end
endmodule

// File: rtl/tc_port.sv
module tc_port
  import tc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tc_clk_i,
  input  logic          tc_addr_i,
  input  logic          tc_clr_i,
  input  logic [DW-1:0] tc_d_i,
  output logic [DW-1:0] tc_q_o,
  output logic          normal_o,
  output logic [DW-1:0] clk_lane_cfg_o,
  output logic [4*DW-1:0] data_lane_cfg_o,
  output logic [DW-1:0] settle_cfg_o
);
  logic [2:0]         ctl_s;
  logic [DW-1:0]      code;
  logic               we;
  logic [DW-1:0]      wdata;
  logic [NREG*DW-1:0] q_all;
  logic [NREG-1:0]    hit;
  logic [DW-1:0]      rdata;

  tc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tc_clr_i, tc_addr_i, tc_clk_i}),
    .q_o   (ctl_s)
  );

  tc_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_s_i(ctl_s[0]),
    .addr_s_i(ctl_s[1]),
    .clr_s_i (ctl_s[2]),
    .bus_i   (tc_d_i),
    .code_o  (code),
    .we_o    (we),
    .wdata_o (wdata),
    .normal_o(normal_o)
  );

  tc_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctl_s[2]),
    .we_i   (we),
    .code_i (code),
    .wdata_i(wdata),
    .q_all_o(q_all),
    .hit_o  (hit),
    .rdata_o(rdata)
  );

  assign tc_q_o          = rdata;
  assign clk_lane_cfg_o  = q_all[0 +: DW];
  assign data_lane_cfg_o = q_all[DW +: 4*DW];
  assign settle_cfg_o    = q_all[5*DW +: DW];

  assert_unimpl_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_q_o != '0) |-> (|hit));

  assert_one_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/tc_port_tb_top.sv
module tc_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tc_clk_i = 1'b0;
  logic        tc_addr_i = 1'b0;
  logic        tc_clr_i = 1'b0;
  logic [7:0]  tc_d_i = 8'h00;
  logic [7:0]  tc_q_o;
  logic        normal_o;
  logic [7:0]  clk_lane_cfg_o;
  logic [31:0] data_lane_cfg_o;
  logic [7:0]  settle_cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [0:255];
  logic [7:0] m_code;
  bit         m_normal;

  always #2 clk_i = ~clk_i;

  tc_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tc_clk_i(tc_clk_i), .tc_addr_i(tc_addr_i),
    .tc_clr_i(tc_clr_i), .tc_d_i(tc_d_i), .tc_q_o(tc_q_o), .normal_o(normal_o),
    .clk_lane_cfg_o(clk_lane_cfg_o), .data_lane_cfg_o(data_lane_cfg_o),
    .settle_cfg_o(settle_cfg_o)
  );

  function automatic bit is_impl(logic [7:0] c);
    return c == 8'h34 || c == 8'h44 || c == 8'h54 || c == 8'h84 ||
           c == 8'h94 || c == 8'h75;
  endfunction

  function automatic logic [7:0] exp_q();
    return is_impl(m_code) ? m_mem[m_code] : 8'h00;
  endfunction

  function automatic logic [55:0] exp_cfg();
    return {m_mem[8'h75], m_mem[8'h94], m_mem[8'h84], m_mem[8'h54],
            m_mem[8'h44], m_mem[8'h34]};
  endfunction

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "readback", {56'd0, tc_q_o}, {56'd0, exp_q()});
    chk(req, "normal", {63'd0, normal_o}, {63'd0, m_normal});
    chk(req, "cfg", {8'd0, settle_cfg_o, data_lane_cfg_o, clk_lane_cfg_o},
        {8'd0, exp_cfg()});
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic put_code(logic [7:0] c);
    tc_addr_i = 1'b1; tc_d_i = c; wait_clk(4);
    tc_clk_i = 1'b1; wait_clk(6);
    tc_clk_i = 1'b0; wait_clk(6);
    tc_addr_i = 1'b0; wait_clk(4);
    m_code = c; m_normal = 1'b0;
  endtask

  task automatic put_data(logic [7:0] d);
    tc_addr_i = 1'b0; tc_d_i = d; wait_clk(4);
    tc_clk_i = 1'b1; wait_clk(6);
    tc_clk_i = 1'b0; wait_clk(6);
    if (is_impl(m_code)) m_mem[m_code] = d;
    if (m_code == 8'h00 && d == 8'h00) m_normal = 1'b1;
  endtask

  // rising edge in code phase, falling edge in data phase: no effect
  task automatic wrong_phase(logic [7:0] v);
    tc_addr_i = 1'b1; tc_d_i = v; wait_clk(4);
    tc_clk_i = 1'b1; wait_clk(6);
    tc_addr_i = 1'b0; wait_clk(4);
    tc_clk_i = 1'b0; wait_clk(6);
  endtask

  task automatic do_clear();
    tc_clr_i = 1'b1; wait_clk(6);
    tc_clr_i = 1'b0; wait_clk(4);
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_code = 8'h00; m_normal = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait_clk(200000 - 100);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] codes [8];
    codes = '{8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75, 8'h00, 8'h10};
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_code = 8'h00; m_normal = 1'b1;
    void'($urandom(32'h5EED_0042));
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    check_all("R1");

    // R2/R3/R7: each implemented code written with a distinct value
    for (int i = 0; i < 6; i++) begin
      put_code(codes[i]);
      check_all("R2");
      put_data(8'h11 * (i + 1));
      check_all("R7");
    end

    // R3 latency: new value visible within 4 clocks of the edge
    put_code(8'h54);
    tc_d_i = 8'hA5; wait_clk(4);
    tc_clk_i = 1'b1; @(posedge clk_i);
    repeat (4) @(posedge clk_i);
    #1;
    chk("R3", "latency", {56'd0, data_lane_cfg_o[15:8]}, {56'd0, 8'hA5});
    wait_clk(4); tc_clk_i = 1'b0; wait_clk(6);
    m_mem[8'h54] = 8'hA5;
    check_all("R3");

    // R4/R5: wrong-phase edges change nothing
    wrong_phase(8'hC3);
    check_all("R4");
    check_all("R5");

    // R6: unimplemented code reads zero, writes are dropped
    put_code(8'h10);
    check_all("R6");
    put_data(8'hFF);
    check_all("R6");

    // R8: nonzero data at code 0x00 keeps test mode, zero data restores normal
    put_code(8'h00);
    check_all("R8");
    put_data(8'h5A);
    check_all("R8");
    put_data(8'h00);
    check_all("R8");

    // R9: clear in the middle of a sequence
    put_code(8'h75);
    do_clear();
    check_all("R9");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        put_code($urandom_range(0, 3) == 0 ? 8'($urandom) : codes[$urandom_range(0, 7)]);
        check_all("R2");
      end else if (op < 8) begin
        put_data($urandom_range(0, 4) == 0 ? 8'h00 : 8'($urandom));
        check_all("R3");
      end else if (op == 8) begin
        wrong_phase(8'($urandom));
        check_all("R4");
      end else begin
        do_clear();
        check_all("R9");
      end
    end
    finish_run();
  end
endmodule